// File: doc/BRIEF.md
# Interference Slowdown Estimator

This block sits beside a shared memory controller and works out, for each of N applications, how much slower it runs because the others compete for memory. Time is cut into fixed intervals. Each interval is made of equal epochs. At the start of each epoch a pseudo-random pick names one application as the top-priority one, and the block drives that choice out on `hp_id` for the request scheduler to honour.

During the interval, per-application counters record five things: serviced requests, serviced requests that arrived while the application held top priority, cycles spent at top priority, interference cycles, and core memory-stall cycles. An interference cycle is one in which the top-priority application still has a request waiting even though another application was issued the cycle before. When the interval ends the counters are copied into a snapshot and cleared. A single shared sequential divider then turns each snapshot into an 8-fraction-bit slowdown figure. The figure combines the memory-phase fraction with the ratio of the alone service rate to the shared service rate. A one-cycle done pulse marks the moment when every application's figure has been written.

Top module: `slowdown_est`

## Requirements
- R1: While and right after reset, `hp_id` equals 1 (seed 0xACE1 mod N, N = 4), every slowdown output reads 0x0100 (1.0 in 8-fraction-bit fixed point), and `est_done` is low.
- R2: The top-priority pick comes from a 16-bit Galois LFSR that shifts right and XORs 0xB400 when the bit shifted out is 1. It is seeded with 0xACE1 and advances once at each epoch boundary, every 16 cycles counted from the first cycle after reset. `hp_id` equals the state mod N and holds constant within an epoch.
- R3: `hp_id` is always below N.
- R4: Each `svc_pulse[i]` counts as one serviced request for application i. When it arrives while `hp_id == i`, it also counts as a top-priority serviced request, so that count never exceeds the serviced count.
- R5: A cycle counts as interference for application i when all three hold: `hp_id == i`, `req_wait[i]` is 1, and in the previous cycle `iss_vld` was 1 with `iss_id != i`. Interference cycles never exceed top-priority cycles.
- R6: An interval lasts 128 cycles (8 epochs of 16). Let S be the stall cycles, H the top-priority serviced requests, P the top-priority cycles, I the interference cycles and C the serviced requests of application i, all in that interval. At the end of the interval the estimate is 256 − floor(256·S/128) + floor(256·S·H/((P−I)·C)). It appears on `slow_flat[16i+15:16i]`.
- R7: If P equals I, including the case P = 0, the application's estimate keeps its previous value.
- R8: `est_done` pulses for exactly one cycle, once per interval from the second interval on, when all N estimates have been written. The estimates do not change in the cycle that follows.
- R9: All counters clear at every interval boundary, so each estimate reflects only its own interval's events.
- R10: An application that stalls in all 128 cycles gets an estimate equal to the rate-ratio term alone, because the first two terms cancel.
- R11: An application with C = 0 gets a rate-ratio term of zero, so its estimate is 256 − floor(256·S/128).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| svc_pulse | input | N | One pulse per serviced request, one bit per application |
| req_wait | input | N | Application has a request waiting in the controller |
| iss_vld | input | 1 | A request was issued this cycle |
| iss_id | input | log2 N | Application that owns the issued request |
| mem_stall | input | N | Core of the application is stalled on memory |
| hp_id | output | log2 N | Application currently holding top priority |
| slow_flat | output | 16·N | Slowdown estimates, 8 fraction bits, application i at bits 16i+15:16i |
| est_done | output | 1 | All estimates of the last interval are written |

## Verification
The intervals are driven with different mixes of request-service periods, stall duty cycles, waiting masks and issue modes. The mixes are: round-robin issue, which gives partial interference; a single issuing application with every other application waiting, which makes P equal I and so tests the hold rule; and no issue at all, which tests the case with no interference. Setting stall to every cycle for some applications and to none for others separates the two terms of the estimate. Applications that receive no service isolate the zero-divisor path. Consecutive intervals with unrelated patterns show that the counters clear at each boundary. Throughout, the top-priority id is compared epoch by epoch against an independent model of the LFSR.

// File: rtl/slw_pkg.sv
package slw_pkg;

    // configuration
    localparam int N_APP     = 4;
    localparam int EPOCH_LG  = 4;               // epoch = 16 cycles
    localparam int EPOCHS_LG = 3;               // 8 epochs per interval
    localparam int FRAC      = 8;               // fraction bits of the estimate
    localparam int LFSR_W    = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
    localparam logic [LFSR_W-1:0] LFSR_MASK = 16'hB400;

    // derived
    localparam int IV_LG  = EPOCH_LG + EPOCHS_LG;
    localparam int CNT_W  = IV_LG + 1;
    localparam int OUT_W  = CNT_W + FRAC;
    localparam int PROD_W = 2 * CNT_W;
    localparam int NUM_W  = PROD_W + FRAC;
    localparam int DEN_W  = PROD_W;
    localparam int DCNT_W = $clog2(NUM_W + 1);
    localparam int ID_W   = (N_APP > 1) ? $clog2(N_APP) : 1;
    localparam logic [OUT_W-1:0] ONE_FX = OUT_W'(1) << FRAC;

    typedef logic [OUT_W-1:0] fx_t;

    typedef struct packed {
        logic [CNT_W-1:0] svc;
        logic [CNT_W-1:0] hpreq;
        logic [CNT_W-1:0] hpcyc;
        logic [CNT_W-1:0] intf;
        logic [CNT_W-1:0] stall;
    } app_snap_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_DIV  = 2'd2
    } est_st_e;

    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return (s >> 1) ^ (s[0] ? LFSR_MASK : '0);
    endfunction

    function automatic logic [ID_W-1:0] pick_app(input logic [LFSR_W-1:0] s);
        return ID_W'(s % LFSR_W'(N_APP));
    endfunction

endpackage

// File: rtl/slw_prio_sel.sv
module slw_prio_sel import slw_pkg::*; (
    input  logic            clk,
    input  logic            rst,
    output logic [ID_W-1:0] hp_id,
    output logic            iv_last
);
    logic [IV_LG-1:0]  cyc;
    logic [LFSR_W-1:0] lfsr;
    logic [LFSR_W-1:0] lfsr_nx;
    logic              ep_last;

    assign ep_last = &cyc[EPOCH_LG-1:0];
    assign iv_last = &cyc;
    assign lfsr_nx = lfsr_next(lfsr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc   <= '0;
            lfsr  <= LFSR_SEED;
            hp_id <= pick_app(LFSR_SEED);
        end else begin
            cyc <= cyc + 1'b1;
            if (ep_last) begin
                lfsr  <= lfsr_nx;
                hp_id <= pick_app(lfsr_nx);
            end
        end
    end
endmodule

// File: rtl/slw_app_ctr.sv
module slw_app_ctr import slw_pkg::*; (
    input  logic      clk,
    input  logic      rst,
    input  logic      is_hp,
    input  logic      svc,
    input  logic      waiting,
    input  logic      other_prev,
    input  logic      stall,
    input  logic      iv_last,
    output app_snap_t snap
);
    app_snap_t cnt;
    app_snap_t nxt;

    always_comb begin
        nxt.svc   = cnt.svc   + CNT_W'(svc);
        nxt.hpreq = cnt.hpreq + CNT_W'(svc & is_hp);
        nxt.hpcyc = cnt.hpcyc + CNT_W'(is_hp);
        nxt.intf  = cnt.intf  + CNT_W'(is_hp & waiting & other_prev);
        nxt.stall = cnt.stall + CNT_W'(stall);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            snap <= '0;
        end else if (iv_last) begin
            snap <= nxt;
            cnt  <= '0;
        end else begin
            cnt <= nxt;
        end
    end
endmodule

// File: rtl/slw_divider.sv
module slw_divider import slw_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    logic [DEN_W-1:0]  rem;
    logic [DEN_W:0]    rem_sh;
    logic [DEN_W-1:0]  den_q;
    logic [DCNT_W-1:0] left;
    logic              busy;
    logic              fits;

    assign rem_sh = {rem, quo[NUM_W-1]};
    assign fits   = (rem_sh >= {1'b0, den_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            rem   <= '0;
            quo   <= '0;
            den_q <= '0;
            left  <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem   <= '0;
                quo   <= num;
                den_q <= den;
                left  <= DCNT_W'(NUM_W);
                busy  <= 1'b1;
            end else if (busy) begin
                if (fits) begin
                    rem <= DEN_W'(rem_sh - {1'b0, den_q});
                end else begin
                    rem <= rem_sh[DEN_W-1:0];
                end
                quo  <= {quo[NUM_W-2:0], fits};
                left <= left - 1'b1;
                if (left == DCNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/slw_est_ctl.sv
module slw_est_ctl import slw_pkg::*; (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   go,
    input  app_snap_t [N_APP-1:0]  snaps,
    output fx_t [N_APP-1:0]        slow_vec,
    output logic                   est_done
);
    est_st_e          st;
    logic [ID_W-1:0]  idx;
    app_snap_t        cur;
    logic [CNT_W-1:0] eff;
    logic [PROD_W-1:0] prod_n;
    logic [DEN_W-1:0] den;
    logic [DEN_W-1:0] den_safe;
    logic [NUM_W-1:0] num;
    fx_t              stall_fx;
    fx_t              base;
    logic             last;
    logic             div_start;
    logic             div_done;
    logic [NUM_W-1:0] quo;
    logic             unused_quo_hi;

    assign cur       = snaps[idx];
    assign eff       = cur.hpcyc - cur.intf;
    assign prod_n    = PROD_W'(cur.stall) * PROD_W'(cur.hpreq);
    assign num       = {prod_n, {FRAC{1'b0}}};
    assign den       = DEN_W'(eff) * DEN_W'(cur.svc);
    assign den_safe  = (den == '0) ? DEN_W'(1) : den;
    assign stall_fx  = {cur.stall, {FRAC{1'b0}}} >> IV_LG;
    assign base      = ONE_FX - stall_fx;
    assign last      = (idx == ID_W'(N_APP - 1));
    assign div_start = (st == ST_LOAD) && (eff != '0);
    assign unused_quo_hi = ^quo[NUM_W-1:OUT_W];

    slw_divider u_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .num   (num),
        .den   (den_safe),
        .done  (div_done),
        .quo   (quo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            idx      <= '0;
            est_done <= 1'b0;
            for (int i = 0; i < N_APP; i++) slow_vec[i] <= ONE_FX;
        end else begin
            est_done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (go) begin
                        idx <= '0;
                        st  <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (eff == '0) begin
                        est_done <= last;
                        if (last) st <= ST_IDLE;
                        else      idx <= idx + 1'b1;
                    end else begin
                        st <= ST_DIV;
                    end
                end
                ST_DIV: begin
                    if (div_done) begin
                        slow_vec[idx] <= base + quo[OUT_W-1:0];
                        est_done      <= last;
                        if (last) begin
                            st <= ST_IDLE;
                        end else begin
                            idx <= idx + 1'b1;
                            st  <= ST_LOAD;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/slowdown_est.sv
module slowdown_est import slw_pkg::*; (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_APP-1:0]       svc_pulse,
    input  logic [N_APP-1:0]       req_wait,
    input  logic                   iss_vld,
    input  logic [ID_W-1:0]        iss_id,
    input  logic [N_APP-1:0]       mem_stall,
    output logic [ID_W-1:0]        hp_id,
    output logic [N_APP*OUT_W-1:0] slow_flat,
    output logic                   est_done
);
    logic                  iv_last;
    logic                  go_q;
    logic                  iss_q_vld;
    logic [ID_W-1:0]       iss_q_id;
    app_snap_t [N_APP-1:0] snaps;
    fx_t [N_APP-1:0]       slow_vec;

    slw_prio_sel u_sel (
        .clk     (clk),
        .rst     (rst),
        .hp_id   (hp_id),
        .iv_last (iv_last)
    );

    // previous-cycle issue and snapshot-ready strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            iss_q_vld <= 1'b0;
            iss_q_id  <= '0;
            go_q      <= 1'b0;
        end else begin
            iss_q_vld <= iss_vld;
            iss_q_id  <= iss_id;
            go_q      <= iv_last;
        end
    end

    for (genvar i = 0; i < N_APP; i++) begin : g_app
        slw_app_ctr u_ctr (
            .clk        (clk),
            .rst        (rst),
            .is_hp      (hp_id == ID_W'(i)),
            .svc        (svc_pulse[i]),
            .waiting    (req_wait[i]),
            .other_prev (iss_q_vld && (iss_q_id != ID_W'(i))),
            .stall      (mem_stall[i]),
            .iv_last    (iv_last),
            .snap       (snaps[i])
        );
    end

    slw_est_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .go       (go_q),
        .snaps    (snaps),
        .slow_vec (slow_vec),
        .est_done (est_done)
    );

    assign slow_flat = slow_vec;
endmodule

// File: rtl/slw_chk.sv
module slw_chk import slw_pkg::*; (
    input logic                   clk,
    input logic                   rst,
    input logic [ID_W-1:0]        hp_id,
    input logic                   est_done,
    input logic [N_APP*OUT_W-1:0] slow_flat,
    input app_snap_t [N_APP-1:0]  snaps
);
    logic                rst_q;
    logic [EPOCH_LG-1:0] ep_c;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q) begin
            p_reset_vals_r1: assert (slow_flat == {N_APP{ONE_FX}} && !est_done
                                     && hp_id == pick_app(LFSR_SEED))
                else $error("reset values wrong");
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ep_c <= '0;
        else     ep_c <= ep_c + 1'b1;
    end

    p_hp_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (ep_c != '0) |-> $stable(hp_id));

    p_hp_range_r3: assert property (@(posedge clk) disable iff (rst)
        32'(hp_id) < N_APP);

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        est_done |=> !est_done);

    p_done_settled_r8: assert property (@(posedge clk) disable iff (rst)
        est_done |=> $stable(slow_flat));

    for (genvar i = 0; i < N_APP; i++) begin : g_bound
        p_hpreq_bound_r4: assert property (@(posedge clk) disable iff (rst)
            snaps[i].hpreq <= snaps[i].svc);
        p_intf_bound_r5: assert property (@(posedge clk) disable iff (rst)
            snaps[i].intf <= snaps[i].hpcyc);
    end
endmodule

bind slowdown_est slw_chk u_slw_chk (
    .clk       (clk),
    .rst       (rst),
    .hp_id     (hp_id),
    .est_done  (est_done),
    .slow_flat (slow_flat),
    .snaps     (snaps)
);

// File: tb/slowdown_est_bench.sv
`timescale 1ns/1ps
module slowdown_est_bench;
    import slw_pkg::*;

    localparam int L         = 1 << IV_LG;
    localparam int EP_LEN    = 1 << EPOCH_LG;
    localparam int CYC_LIMIT = 200000;

    // per-interval stimulus: nibble i of per/stl belongs to application i
    typedef struct packed {
        logic [15:0] per;   // service period, 0 = never
        logic [15:0] stl;   // stall eighths (stall when cycle%8 < value)
        logic [3:0]  wm;    // waiting mask
        logic [1:0]  iss;   // 0 none, 1 round robin (cycle%4), 2 always app 0
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{per: 16'h0432, stl: 16'h0284, wm: 4'hF, iss: 2'd1},
        '{per: 16'h7511, stl: 16'h1638, wm: 4'hA, iss: 2'd1},
        '{per: 16'h3242, stl: 16'h5555, wm: 4'hF, iss: 2'd2},
        '{per: 16'h1023, stl: 16'h2880, wm: 4'h5, iss: 2'd0},
        '{per: 16'h6666, stl: 16'h8317, wm: 4'hF, iss: 2'd1}
    };
    localparam vec_t IDLE_V = '{per: 16'h0, stl: 16'h0, wm: 4'h0, iss: 2'd0};

    logic                   clk = 1'b0;
    logic                   rst;
    logic [N_APP-1:0]       svc_pulse;
    logic [N_APP-1:0]       req_wait;
    logic                   iss_vld;
    logic [ID_W-1:0]        iss_id;
    logic [N_APP-1:0]       mem_stall;
    logic [ID_W-1:0]        hp_id;
    logic [N_APP*OUT_W-1:0] slow_flat;
    logic                   est_done;

    always #2 clk = ~clk;

    slowdown_est u_slowdown_est (
        .clk       (clk),
        .rst       (rst),
        .svc_pulse (svc_pulse),
        .req_wait  (req_wait),
        .iss_vld   (iss_vld),
        .iss_id    (iss_id),
        .mem_stall (mem_stall),
        .hp_id     (hp_id),
        .slow_flat (slow_flat),
        .est_done  (est_done)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          finished = 0;
    logic [15:0] lf_m;
    int          gcyc;
    bit          pv;
    int          pid;
    longint      c_svc[N_APP], c_hpr[N_APP], c_hpc[N_APP], c_inf[N_APP], c_stl[N_APP];
    longint      last_est[N_APP];
    longint      pend_est[N_APP];
    string       pend_lbl[N_APP];
    bit          pend_vld;

    function automatic void chk(bit ok, string req, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endfunction

    function automatic logic [15:0] model_step(logic [15:0] s);
        logic [15:0] t;
        t = {1'b0, s[15:1]};
        if (s[0]) t = t ^ 16'hB400;
        return t;
    endfunction

    function automatic longint slot(int i);
        return longint'(slow_flat[i*OUT_W +: OUT_W]);
    endfunction

    task automatic check_reset_state(string tag);
        chk(hp_id == ID_W'(16'hACE1 % N_APP), {tag, " hp_id"}, longint'(hp_id), 16'hACE1 % N_APP);
        for (int i = 0; i < N_APP; i++)
            chk(slot(i) == 256, {tag, " slowdown"}, slot(i), 256);
        chk(est_done == 1'b0, {tag, " done"}, longint'(est_done), 0);
    endtask

    task automatic run_interval(input vec_t v);
        int dones = 0;
        bit expect_done = pend_vld;
        for (int i = 0; i < N_APP; i++) begin
            c_svc[i] = 0; c_hpr[i] = 0; c_hpc[i] = 0; c_inf[i] = 0; c_stl[i] = 0;
        end
        for (int c = 0; c < L; c++) begin
            int hp;
            // outputs from the edge just past
            if (est_done) begin
                dones++;
                if (pend_vld) begin
                    for (int i = 0; i < N_APP; i++)
                        chk(slot(i) == pend_est[i], pend_lbl[i], slot(i), pend_est[i]);
                    pend_vld = 0;
                end
            end
            if (gcyc % EP_LEN == 0) begin
                if (gcyc != 0) lf_m = model_step(lf_m);
                chk(int'(hp_id) == int'(lf_m) % N_APP, "R2 epoch pick",
                    longint'(hp_id), int'(lf_m) % N_APP);
                if (c == 0) chk(int'(hp_id) < N_APP, "R3 range", longint'(hp_id), N_APP - 1);
            end
            hp = int'(hp_id);
            // drive this cycle
            for (int i = 0; i < N_APP; i++) begin
                int p = int'(v.per[i*4 +: 4]);
                int s = int'(v.stl[i*4 +: 4]);
                svc_pulse[i] = (p != 0) && ((c % p) == 0);
                mem_stall[i] = (c % 8) < s;
                req_wait[i]  = v.wm[i];
            end
            case (v.iss)
                2'd1:    begin iss_vld = 1'b1; iss_id = ID_W'(c % N_APP); end
                2'd2:    begin iss_vld = 1'b1; iss_id = '0; end
                default: begin iss_vld = 1'b0; iss_id = '0; end
            endcase
            for (int i = 0; i < N_APP; i++) begin
                if (svc_pulse[i]) c_svc[i]++;
                if (svc_pulse[i] && hp == i) c_hpr[i]++;
                if (hp == i) c_hpc[i]++;
                if (hp == i && req_wait[i] && pv && pid != i) c_inf[i]++;
                if (mem_stall[i]) c_stl[i]++;
            end
            pv  = iss_vld;
            pid = int'(iss_id);
            gcyc++;
            @(negedge clk);
        end
        chk(dones == (expect_done ? 1 : 0), "R8 one done per interval", dones, expect_done ? 1 : 0);
        // R9: the expectation uses only this interval's counts
        for (int i = 0; i < N_APP; i++) begin
            longint eff = c_hpc[i] - c_inf[i];
            if (eff == 0) begin
                pend_est[i] = last_est[i];
                pend_lbl[i] = "R7 estimate held";
            end else begin
                longint base = 256 - ((c_stl[i] * 256) >> IV_LG);
                longint q = (c_svc[i] == 0) ? 0 : (c_stl[i] * c_hpr[i] * 256) / (eff * c_svc[i]);
                pend_est[i] = base + q;
                if (c_svc[i] == 0)        pend_lbl[i] = "R11 no service";
                else if (c_stl[i] == L)   pend_lbl[i] = "R10 memory bound";
                else                      pend_lbl[i] = "R6 estimate (R4,R5 counts, R9 fresh)";
            end
            last_est[i] = pend_est[i];
        end
        pend_vld = 1;
    endtask

    initial begin
        rst       = 1'b1;
        svc_pulse = '0;
        req_wait  = '0;
        iss_vld   = 1'b0;
        iss_id    = '0;
        mem_stall = '0;
        for (int i = 0; i < N_APP; i++) last_est[i] = 256;
        pend_vld = 0;
        repeat (3) @(negedge clk);
        check_reset_state("R1 after reset");
        rst  = 1'b0;
        lf_m = 16'hACE1;
        gcyc = 0;
        pv   = 0;
        pid  = 0;
        foreach (VECS[k]) run_interval(VECS[k]);
        run_interval(IDLE_V);
        // directed: reset in the middle of operation
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check_reset_state("R1 mid-run reset");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CYC_LIMIT * 4);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual 0 expected 1 finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule